// File: doc/BRIEF.md
# Flash block erase sequencer

This controller carries out the whole erase and erase-verify procedure for one flash block without software stepping through it. A pulse on `start` latches the block number and a set of cycle-count timings into internal registers. The controller then drives the flash array control levels in a fixed order: write enable, block select, erase setup and erase. After that it leaves erase mode and sweeps the block in verify mode. For each word it issues a dummy write of all ones and reads the word back.

A word that does not read back as all ones ends the sweep early. The controller then leaves verify mode and applies another erase pulse, up to a programmable maximum number of attempts. A guard counter is armed for the erase-mode window and forces a safe exit if it runs out. Every exit path lowers the control levels in the same order with the same minimum settle times. The result is reported on `done` or `fail`. Both stay set until the next start.

Every "wait at least t" in this block means that a level stays in its phase for max(t, 1) clock cycles before the next transition. A block holds 2^OFF_W words. The flash address is the block number in the upper bits and the word offset in the lower bits.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is low, and after it is released until a start, all flash control levels, `fl_we`, `done`, `fail` and `guard_fault` are 0 and `tries` is 0.
- R2: `fl_swe` rises first. Block select rises no earlier than max(`t_swe_setup`,1) cycles after it. Block select is only high while `fl_swe` is high.
- R3: `fl_esu` rises only while a block is selected. `fl_erase` rises only after `fl_esu` has been high for max(`t_esu_setup`,1) cycles, and it is high only while `fl_esu` and `fl_swe` are high.
- R4: Each erase pulse lasts exactly max(1, min(`t_erase`, T_ERASE_MAX)) cycles and never exceeds T_ERASE_MAX.
- R5: After `fl_erase` falls, `fl_esu` stays high for max(`t_erase_hold`,1) cycles. `fl_ev` is never high together with `fl_esu`.
- R6: In verify mode the first dummy write comes max(`t_ev_setup`,1) cycles after `fl_ev` rises. Every dummy write has `fl_wdata` = 16'hFFFF and `fl_addr` = {block, offset}, with the offset starting at 0 and rising by one per write. The word is sampled max(`t_evr_setup`,1) cycles after its write.
- R7: A word that is not 16'hFFFF stops the sweep. The controller then leaves verify mode and, if attempts remain, applies a new erase pulse followed by a new sweep from offset 0. `tries` counts erase pulses.
- R8: When every word of the block reads 16'hFFFF, `fl_ev` falls. `fl_swe` falls max(`t_ev_exit`,1) cycles later, and `done` rises max(`t_swe_clear`,1) cycles after that, with `fail` = 0. `done` and `fail` are never both 1.
- R9: If verify fails after `max_tries` pulses (at least one), `fail` = 1, `done` = 0 and `tries` = `max_tries`, with the levels lowered in the R8 order.
- R10: The guard counter is loaded with `guard_period` when the block select phase starts. If it expires before erase mode is left, `fl_erase` is low on the next cycle, `fl_esu` then drops after the hold time, verify mode is never entered, and `guard_fault` = `fail` = 1.
- R11: Only the block latched at start is selected: `fl_blk` is zero or the one-hot code of that block, and no other block receives an erase pulse.
- R12: `start` and `blk_sel` have no effect while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled when idle) |
| blk_sel | input | BLK_W | Block number to erase |
| t_swe_setup | input | CW | Cycles from write enable to block select |
| t_esu_setup | input | CW | Cycles from erase setup to erase |
| t_erase | input | CW | Requested erase pulse length |
| t_erase_hold | input | CW | Cycles from erase low to erase setup low |
| t_ev_setup | input | CW | Cycles from verify level to first dummy write |
| t_evr_setup | input | CW | Cycles from dummy write to read sample |
| t_ev_exit | input | CW | Cycles from verify low to write enable low |
| t_swe_clear | input | CW | Cycles from write enable low to completion |
| guard_period | input | GW | Guard counter reload value |
| max_tries | input | TRY_W | Maximum erase pulses |
| fl_swe | output | 1 | Write enable level |
| fl_esu | output | 1 | Erase setup level |
| fl_erase | output | 1 | Erase level |
| fl_ev | output | 1 | Erase-verify level |
| fl_blk | output | NBLK | One-hot block select |
| fl_addr | output | AW | Word address {block, offset} |
| fl_we | output | 1 | Dummy write strobe |
| fl_wdata | output | DW | Dummy write data |
| fl_rdata | input | DW | Read data at the latched address |
| done | output | 1 | Block verified erased |
| fail | output | 1 | Sequence ended without a clean verify |
| guard_fault | output | 1 | Guard counter expired in erase mode |
| tries | output | TRY_W | Erase pulses applied in this sequence |

## Verification
The hardest state to reach from the ports is a guard expiry while the erase level is high, because a sensible configuration never allows it. The bench reaches it by giving a guard period shorter than the setup time plus the requested pulse. It then checks that the pulse is cut short, that verify mode is never entered and that the fault is reported. Retry and exhaustion paths are reached through a behavioural array model. In that model one word of the target block needs a chosen number of pulses before it reads erased, and a read taken too soon after its dummy write returns unerased data, so a shortened read setup wait shows up as extra retries.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SWE_SU,
    ST_SEL,
    ST_ESU_SU,
    ST_ERASE,
    ST_E_HOLD,
    ST_EV_SU,
    ST_EV_WR,
    ST_EV_RD,
    ST_EV_EXIT,
    ST_SWE_CLR
  } fes_state_e;

  typedef enum logic [1:0] {
    OC_PASS,
    OC_RETRY,
    OC_FAIL
  } fes_outcome_e;

endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // phase length is max(load_val, 1) cycles
  assign expired = (cnt_q <= CW'(1));

endmodule

// File: rtl/fes_guard.sv
module fes_guard #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          armed,
  input  logic [GW-1:0] period,
  output logic          expired
);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (armed && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                        cnt_d = period;
    else if (armed && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = armed && (cnt_q == '0);

  // R10
  guard_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(period)));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int NBLK        = 4,
  parameter int OFF_W       = 3,
  parameter int DW          = 16,
  parameter int CW          = 12,
  parameter int GW          = 16,
  parameter int TRY_W       = 4,
  parameter int T_ERASE_MAX = 16,
  localparam int BLK_W      = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int AW         = BLK_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_sel,
  input  logic [CW-1:0]    t_swe_setup,
  input  logic [CW-1:0]    t_esu_setup,
  input  logic [CW-1:0]    t_erase,
  input  logic [CW-1:0]    t_erase_hold,
  input  logic [CW-1:0]    t_ev_setup,
  input  logic [CW-1:0]    t_evr_setup,
  input  logic [CW-1:0]    t_ev_exit,
  input  logic [CW-1:0]    t_swe_clear,
  input  logic [GW-1:0]    guard_period,
  input  logic [TRY_W-1:0] max_tries,
  output logic             fl_swe,
  output logic             fl_esu,
  output logic             fl_erase,
  output logic             fl_ev,
  output logic [NBLK-1:0]  fl_blk,
  output logic [AW-1:0]    fl_addr,
  output logic             fl_we,
  output logic [DW-1:0]    fl_wdata,
  input  logic [DW-1:0]    fl_rdata,
  output logic             done,
  output logic             fail,
  output logic             guard_fault,
  output logic [TRY_W-1:0] tries
);

  localparam logic [CW-1:0]    ER_CAP   = CW'(T_ERASE_MAX);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  fes_state_e         state_q, state_d;
  fes_outcome_e       oc_q, oc_d;
  logic [BLK_W-1:0]   blk_q, blk_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic [TRY_W-1:0]   tries_q, tries_d;
  logic               done_q, done_d, fail_q, fail_d, gf_q, gf_d;

  // timing registers, written once per start
  logic [CW-1:0]      cfg_esu_q, cfg_er_q, cfg_hold_q, cfg_evs_q;
  logic [CW-1:0]      cfg_evr_q, cfg_evx_q, cfg_swc_q;
  logic [GW-1:0]      cfg_guard_q;
  logic [TRY_W-1:0]   cfg_tries_q;
  logic               cfg_en;

  logic               tm_load, tm_exp;
  logic [CW-1:0]      tm_val;
  logic               g_load, g_armed, g_exp, abort;
  logic               blk_on;

  assign cfg_en = (state_q == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_esu_q   <= '0;
      cfg_er_q    <= '0;
      cfg_hold_q  <= '0;
      cfg_evs_q   <= '0;
      cfg_evr_q   <= '0;
      cfg_evx_q   <= '0;
      cfg_swc_q   <= '0;
      cfg_guard_q <= '0;
      cfg_tries_q <= '0;
    end else if (cfg_en) begin
      cfg_esu_q   <= t_esu_setup;
      cfg_er_q    <= (t_erase > ER_CAP) ? ER_CAP : t_erase;
      cfg_hold_q  <= t_erase_hold;
      cfg_evs_q   <= t_ev_setup;
      cfg_evr_q   <= t_evr_setup;
      cfg_evx_q   <= t_ev_exit;
      cfg_swc_q   <= t_swe_clear;
      cfg_guard_q <= guard_period;
      cfg_tries_q <= max_tries;
    end
  end

  // guard window covers block select through erase hold
  assign g_armed = (state_q == ST_SEL) || (state_q == ST_ESU_SU) ||
                   (state_q == ST_ERASE) || (state_q == ST_E_HOLD);
  assign g_load  = (state_d == ST_SEL) && (state_q != ST_SEL);
  assign abort   = g_exp && (state_q != ST_E_HOLD);

  fes_guard #(.GW(GW)) guard_i (
    .clk(clk), .rst_n(rst_n), .load(g_load), .armed(g_armed),
    .period(cfg_guard_q), .expired(g_exp)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    oc_d    = oc_q;
    blk_d   = blk_q;
    off_d   = off_q;
    tries_d = tries_q;
    done_d  = done_q;
    fail_d  = fail_q;
    gf_d    = gf_q;
    if (abort) begin
      state_d = ST_E_HOLD;
      oc_d    = OC_FAIL;
      gf_d    = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_d = ST_SWE_SU;
          blk_d   = blk_sel;
          tries_d = '0;
          done_d  = 1'b0;
          fail_d  = 1'b0;
          gf_d    = 1'b0;
        end
        ST_SWE_SU:  if (tm_exp) state_d = ST_SEL;
        ST_SEL:     state_d = ST_ESU_SU;
        ST_ESU_SU:  if (tm_exp) begin
          state_d = ST_ERASE;
          oc_d    = OC_PASS;
          tries_d = tries_q + 1'b1;
        end
        ST_ERASE:   if (tm_exp) state_d = ST_E_HOLD;
        ST_E_HOLD:  if (tm_exp) begin
          state_d = (oc_q == OC_FAIL) ? ST_EV_EXIT : ST_EV_SU;
          off_d   = '0;
        end
        ST_EV_SU:   if (tm_exp) state_d = ST_EV_WR;
        ST_EV_WR:   state_d = ST_EV_RD;
        ST_EV_RD:   if (tm_exp) begin
          if (fl_rdata == '1) begin
            if (off_q == LAST_OFF) state_d = ST_EV_EXIT;
            else begin
              state_d = ST_EV_WR;
              off_d   = off_q + 1'b1;
            end
          end else begin
            state_d = ST_EV_EXIT;
            oc_d    = (tries_q >= cfg_tries_q) ? OC_FAIL : OC_RETRY;
          end
        end
        ST_EV_EXIT: if (tm_exp) state_d = (oc_q == OC_RETRY) ? ST_SEL : ST_SWE_CLR;
        ST_SWE_CLR: if (tm_exp) begin
          state_d = ST_IDLE;
          done_d  = (oc_q == OC_PASS);
          fail_d  = (oc_q == OC_FAIL);
        end
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  // phase length selected by the phase being entered
  assign tm_load = (state_d != state_q);
  always_comb begin
    case (state_d)
      ST_SWE_SU:  tm_val = t_swe_setup;
      ST_ESU_SU:  tm_val = cfg_esu_q;
      ST_ERASE:   tm_val = cfg_er_q;
      ST_E_HOLD:  tm_val = cfg_hold_q;
      ST_EV_SU:   tm_val = cfg_evs_q;
      ST_EV_RD:   tm_val = cfg_evr_q;
      ST_EV_EXIT: tm_val = cfg_evx_q;
      ST_SWE_CLR: tm_val = cfg_swc_q;
      default:    tm_val = CW'(1);
    endcase
  end

  fes_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .expired(tm_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oc_q    <= OC_PASS;
      blk_q   <= '0;
      off_q   <= '0;
      tries_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      gf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      oc_q    <= oc_d;
      blk_q   <= blk_d;
      off_q   <= off_d;
      tries_q <= tries_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      gf_q    <= gf_d;
    end
  end

  // control level decode
  assign fl_swe   = (state_q != ST_IDLE) && (state_q != ST_SWE_CLR);
  assign blk_on   = (state_q >= ST_SEL) && (state_q <= ST_EV_EXIT);
  assign fl_esu   = (state_q == ST_ESU_SU) || (state_q == ST_ERASE) || (state_q == ST_E_HOLD);
  assign fl_erase = (state_q == ST_ERASE);
  assign fl_ev    = (state_q == ST_EV_SU) || (state_q == ST_EV_WR) || (state_q == ST_EV_RD);
  assign fl_we    = (state_q == ST_EV_WR);
  assign fl_wdata = '1;
  assign fl_addr  = {blk_q, off_q};

  for (genvar gi = 0; gi < NBLK; gi++) begin : g_blk
    assign fl_blk[gi] = blk_on && (blk_q == BLK_W'(gi));
  end

  assign done        = done_q;
  assign fail        = fail_q;
  assign guard_fault = gf_q;
  assign tries       = tries_q;

  // erase run length, for the pulse cap check
  logic [CW:0] er_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        er_run_q <= '0;
    else if (fl_erase) er_run_q <= er_run_q + 1'b1;
    else               er_run_q <= '0;
  end

  // R2
  swe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_blk != '0) |-> fl_swe);
  // R3
  erase_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> (fl_esu && fl_swe && (fl_blk != '0)));
  // R3
  erase_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_erase) |-> $past(fl_esu));
  // R4
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> (er_run_q < (CW+1)'(T_ERASE_MAX)));
  // R5
  setup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_esu) |-> $past(!fl_erase));
  // R5
  verify_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_ev && fl_esu));
  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R10
  guard_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_exp && fl_erase) |=> !fl_erase);
  // R11
  blk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_blk));
  // R12
  blk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_swe && $past(fl_swe)) |-> $stable(blk_q));

endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBLK   = 4;
  localparam int OFF_W  = 3;
  localparam int DW     = 16;
  localparam int CW     = 12;
  localparam int GW     = 16;
  localparam int TRY_W  = 4;
  localparam int ER_MAX = 16;
  localparam int BLK_W  = 2;
  localparam int AW     = BLK_W + OFF_W;
  localparam int WPB    = 1 << OFF_W;
  localparam int NWORDS = NBLK * WPB;
  localparam int STUBBORN = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             rst_n, start;
  logic [BLK_W-1:0] blk_sel;
  logic [CW-1:0]    t_swe, t_esu, t_er, t_hold, t_evs, t_evr, t_evx, t_swc;
  logic [GW-1:0]    guard_period;
  logic [TRY_W-1:0] max_tries;
  logic             fl_swe, fl_esu, fl_erase, fl_ev, fl_we;
  logic [NBLK-1:0]  fl_blk;
  logic [AW-1:0]    fl_addr;
  logic [DW-1:0]    fl_wdata, fl_rdata;
  logic             done, fail, guard_fault;
  logic [TRY_W-1:0] tries;

  flash_erase_seq #(.NBLK(NBLK), .OFF_W(OFF_W), .DW(DW), .CW(CW), .GW(GW),
                    .TRY_W(TRY_W), .T_ERASE_MAX(ER_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel),
    .t_swe_setup(t_swe), .t_esu_setup(t_esu), .t_erase(t_er), .t_erase_hold(t_hold),
    .t_ev_setup(t_evs), .t_evr_setup(t_evr), .t_ev_exit(t_evx), .t_swe_clear(t_swc),
    .guard_period(guard_period), .max_tries(max_tries),
    .fl_swe(fl_swe), .fl_esu(fl_esu), .fl_erase(fl_erase), .fl_ev(fl_ev),
    .fl_blk(fl_blk), .fl_addr(fl_addr), .fl_we(fl_we), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .done(done), .fail(fail), .guard_fault(guard_fault),
    .tries(tries)
  );

  // test settings, driven by the stimulus process only
  logic [BLK_W-1:0] tm_blk;
  int tm_need, tm_swe, tm_esu, tm_hold, tm_evs, tm_evr, tm_evx, tm_swc;
  logic mdl_init;

  // array model and protocol monitor state
  int need [NWORDS];
  logic [AW-1:0] lat_addr;
  int age, cyc;
  logic [NBLK-1:0] er_blk;
  logic p_swe, p_blk, p_esu, p_er, p_ev, p_done, wr_seen;
  int t_swe_r, t_esu_r, t_er_r, t_er_f, t_ev_r, t_ev_f, t_swe_f;
  int v2, v3, v5, v6, v8, v11, ev_rises, last_width;
  logic [OFF_W-1:0] exp_off;

  assign fl_rdata = (need[lat_addr] == 0 && age >= tm_evr) ? 16'hFFFF : 16'h0F0F;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdl_init) begin
      for (int w = 0; w < NWORDS; w++)
        need[w] = (w == int'(tm_blk) * WPB + STUBBORN) ? tm_need : 1;
      lat_addr = '0; age = 0; er_blk = '0;
      v2 = 0; v3 = 0; v5 = 0; v6 = 0; v8 = 0; v11 = 0;
      ev_rises = 0; last_width = 0; exp_off = '0; wr_seen = 1'b0;
      t_swe_r = 0; t_esu_r = 0; t_er_r = 0; t_er_f = 0; t_ev_r = 0; t_ev_f = 0; t_swe_f = 0;
    end else begin
      // array model
      if (fl_we && fl_ev) begin lat_addr = fl_addr; age = 0; end
      else if (age < 100000) age = age + 1;
      if (fl_erase) er_blk = fl_blk;
      if (p_er && !fl_erase)
        for (int w = 0; w < NWORDS; w++)
          if (er_blk[w / WPB] && need[w] > 0) need[w] = need[w] - 1;
      // monitor
      if (fl_swe && !p_swe) t_swe_r = cyc;
      if ((|fl_blk) && !p_blk)
        if (!fl_swe || cyc - t_swe_r < tm_swe) v2++;
      if ((|fl_blk) && !fl_swe) v2++;
      if ((|fl_blk) && fl_blk != NBLK'(1) << tm_blk) v11++;
      if (fl_esu && !p_esu) begin t_esu_r = cyc; if (!(|fl_blk)) v3++; end
      if (fl_erase && !p_er) begin
        t_er_r = cyc;
        if (!fl_esu || cyc - t_esu_r < tm_esu) v3++;
      end
      if (fl_erase && !(fl_esu && fl_swe)) v3++;
      if (!fl_erase && p_er) begin t_er_f = cyc; last_width = cyc - t_er_r; end
      if (!fl_esu && p_esu && cyc - t_er_f < tm_hold) v5++;
      if (fl_ev && fl_esu) v5++;
      if (fl_ev && !p_ev) begin t_ev_r = cyc; ev_rises++; exp_off = '0; wr_seen = 1'b0; end
      if (fl_we) begin
        if (!fl_ev || fl_wdata != 16'hFFFF || fl_addr != {tm_blk, exp_off}) v6++;
        if (!wr_seen && cyc - t_ev_r < tm_evs) v6++;
        wr_seen = 1'b1;
        exp_off = exp_off + 1'b1;
      end
      if (!fl_ev && p_ev) t_ev_f = cyc;
      if (!fl_swe && p_swe) begin
        if (ev_rises > 0 && cyc - t_ev_f < tm_evx) v8++;
        t_swe_f = cyc;
      end
      if ((done || fail) && !p_done && cyc - t_swe_f < tm_swc) v8++;
    end
    p_swe = fl_swe; p_blk = |fl_blk; p_esu = fl_esu; p_er = fl_erase;
    p_ev = fl_ev; p_done = done || fail;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int blk, input int nd, input int maxt, input int ter,
                          input int tb, input int guard, input bit glitch);
    tm_blk = BLK_W'(blk); tm_need = nd;
    tm_swe = tb; tm_esu = tb + 1; tm_hold = tb; tm_evs = tb + 1;
    tm_evr = tb + 2; tm_evx = tb; tm_swc = tb + 1;
    t_swe = CW'(tm_swe); t_esu = CW'(tm_esu); t_er = CW'(ter); t_hold = CW'(tm_hold);
    t_evs = CW'(tm_evs); t_evr = CW'(tm_evr); t_evx = CW'(tm_evx); t_swc = CW'(tm_swc);
    guard_period = GW'(guard); max_tries = TRY_W'(maxt); blk_sel = tm_blk;
    mdl_init = 1'b1;
    @(negedge clk);
    mdl_init = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // R8 R9: results cleared by a new start
    chk(!done && !fail && !guard_fault && fl_swe, "R8 results cleared on start",
        {done, fail, guard_fault}, 0);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (glitch && i == 20) begin start = 1'b1; blk_sel = tm_blk + 1'b1; end
      else begin start = 1'b0; blk_sel = tm_blk; end
      if (done || fail) break;
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic post_checks(input string tag);
    chk(v2 == 0, {tag, " R2 write-enable before block select"}, v2, 0);
    chk(v3 == 0, {tag, " R3 erase setup order"}, v3, 0);
    chk(v5 == 0, {tag, " R5 erase hold and verify exclusion"}, v5, 0);
    chk(v8 == 0, {tag, " R8 exit order and waits"}, v8, 0);
    chk(v11 == 0, {tag, " R11 block select code"}, v11, 0);
    chk(!fl_swe && !fl_esu && !fl_erase && !fl_ev && fl_blk == '0,
        {tag, " R9 levels low at end"}, {fl_swe, fl_esu, fl_erase, fl_ev}, 0);
    begin
      int touched = 0;
      for (int w = 0; w < NWORDS; w++)
        if (w / WPB != int'(tm_blk) && need[w] != 1) touched++;
      chk(touched == 0, {tag, " R11 other blocks untouched"}, touched, 0);
    end
  endtask

  typedef struct packed {
    int blk; int nd; int maxt; int ter; int tb; int exp_done;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{0, 1, 3, 4,  1, 1},
    '{2, 2, 3, 6,  3, 1},
    '{3, 3, 3, 2,  2, 1},
    '{1, 5, 3, 3,  1, 0},
    '{1, 1, 1, 40, 0, 1}
  };

  initial begin
    rst_n = 1'b0; start = 1'b0; blk_sel = '0; mdl_init = 1'b1;
    tm_blk = '0; tm_need = 1; tm_swe = 0; tm_esu = 0; tm_hold = 0; tm_evs = 0;
    tm_evr = 0; tm_evx = 0; tm_swc = 0; cyc = 0;
    t_swe = '0; t_esu = '0; t_er = '0; t_hold = '0; t_evs = '0; t_evr = '0;
    t_evx = '0; t_swc = '0; guard_period = '0; max_tries = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({fl_swe, fl_esu, fl_erase, fl_ev, fl_we} == '0 && fl_blk == '0,
        "R1 levels low in reset", {fl_swe, fl_esu, fl_erase, fl_ev, fl_we}, 0);
    chk(!done && !fail && !guard_fault && tries == '0, "R1 status clear in reset",
        {done, fail, guard_fault, tries}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!fl_swe && !done && !fail && tries == '0, "R1 idle after reset release",
        {fl_swe, done, fail}, 0);

    for (int k = 0; k < 5; k++) begin
      int exp_tries;
      int exp_w;
      exp_tries = TBL[k].exp_done ? TBL[k].nd : TBL[k].maxt;
      exp_w = (TBL[k].ter > ER_MAX) ? ER_MAX : TBL[k].ter;
      if (exp_w < 1) exp_w = 1;
      run_case(TBL[k].blk, TBL[k].nd, TBL[k].maxt, TBL[k].ter, TBL[k].tb, 200, 1'b0);
      if (TBL[k].exp_done != 0) chk(done && !fail, "R8 done on clean verify", {done, fail}, 2);
      else chk(fail && !done, "R9 fail after max tries", {done, fail}, 1);
      chk(int'(tries) == exp_tries, "R7 erase pulse count", tries, exp_tries);
      chk(ev_rises == exp_tries, "R7 one verify sweep per pulse", ev_rises, exp_tries);
      chk(last_width == exp_w, "R4 erase pulse width", last_width, exp_w);
      chk(v6 == 0, "R6 dummy write data, address and timing", v6, 0);
      chk(!guard_fault, "R10 no guard fault in normal run", guard_fault, 0);
      post_checks("table");
    end

    // R10: guard shorter than setup plus pulse
    run_case(1, 1, 3, 20, 2, 8, 1'b0);
    chk(guard_fault && fail && !done, "R10 guard fault reported",
        {guard_fault, fail, done}, 6);
    chk(ev_rises == 0, "R10 verify never entered", ev_rises, 0);
    chk(last_width > 0 && last_width <= 8 && last_width < 20, "R10 pulse cut short",
        last_width, 5);
    chk(int'(tries) == 1, "R10 single pulse", tries, 1);
    post_checks("guard");

    // R12: start and block number changed mid-run
    run_case(2, 2, 3, 5, 3, 200, 1'b1);
    chk(done && !fail, "R12 result unaffected by start while busy", {done, fail}, 2);
    chk(int'(tries) == 2, "R12 pulse count unaffected", tries, 2);
    chk(v6 == 0, "R12 verify addresses stay in latched block", v6, 0);
    post_checks("busy");

    // R9: zero attempts limit still gives one pulse
    run_case(0, 2, 0, 3, 1, 200, 1'b0);
    chk(fail && !done && int'(tries) == 1, "R9 limit of zero treated as one",
        tries, 1);
    post_checks("limit0");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

endmodule